// File: doc/BRIEF.md
# Nested Core Event Controller

This block sits between a set of event-class request lines and a processor core. Each of the 16 event classes has a bit in a latch register that catches the request and keeps it. A mask register and a global enable decide which latched classes may be serviced. The controller offers the core the most urgent serviceable class as a vector index. It does so only when that class outranks every level that is already running or preempted.

When the core accepts the offered index, the controller clears that class's latch bit and records the level in a nesting register. A return pulse from the core retires the most urgent active level. The next cycle's arbitration can then hand a waiting, less urgent class to the core. A small register port gives supervisor-mode access to the latch, mask and nesting registers, each under its own access rule. The global enable is driven only by dedicated set and clear commands.

Priority is fixed by bit index, and a lower index is more urgent. Classes 0 to 4 are system classes that cannot be masked. Classes 5 and 6 depend on the mask alone. Classes 7 to 15 are general-purpose classes and need both the mask and the global enable.

Top module: `nested_event_ctrl`

## Requirements
- R1: After reset, the latch, mask and nesting registers all read 0 in supervisor mode, the global enable is off and `vec_req_o` is 0.
- R2: A 1 on bit i of `ev_req_i` at a clock edge sets latch bit i, whatever the mask holds. The bit stays set until that class is accepted or software overwrites it.
- R3: A supervisor write with `reg_sel_i`=0 (latch) changes only the latch bits whose mask bit is 0. Latch bits whose mask bit is 1 keep their value.
- R4: The mask register is selected with `reg_sel_i`=1. Writes made with `sup_mode_i`=0 leave it unchanged. Every read with `sup_mode_i`=0 returns 0, whatever register is selected.
- R5: The nesting register is selected with `reg_sel_i`=2 and reads back in supervisor mode. Writes to it have no effect. `reg_sel_i`=3 reads 0.
- R6: A latched class 0..4 is always eligible. A latched class 5..6 is eligible only when its mask bit is 1. A latched class 7..15 is eligible only when its mask bit is 1 and the global enable is on.
- R7: A pulse on `gie_set_i` turns the global enable on and a pulse on `gie_clr_i` turns it off; when both are high, clear wins. Neither pulse changes the mask register.
- R8: `vec_req_o` is 1 and `vec_idx_o` is the lowest eligible latched index, but only for an index strictly lower than the lowest set nesting bit. With no nesting bit set, any eligible class qualifies.
- R9: `vec_ack_i` while `vec_req_o` is 1 clears latch bit `vec_idx_o` and sets the same nesting bit at that edge. If `ev_req_i` asserts the same class in that cycle, the latch bit stays set.
- R10: A `ret_i` pulse clears the lowest set nesting bit. The request outputs reflect the reduced nesting state from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_req_i | input | 16 | Event-class request lines, one per class |
| gie_set_i | input | 1 | Turn global enable on |
| gie_clr_i | input | 1 | Turn global enable off |
| sup_mode_i | input | 1 | Access made in supervisor mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 latch, 1 mask, 2 nesting |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| vec_req_o | output | 1 | Vector request to core |
| vec_idx_o | output | 4 | Requested event class index |
| vec_ack_i | input | 1 | Core accepts the requested index |
| ret_i | input | 1 | Return from the most urgent active level |

## Verification
Faults in the latch or nesting registers show up on `vec_req_o` and `vec_idx_o` in the very next cycle. Two failures are visible there at once: a lost latch bit means a class is never offered, and a nesting bit that fails to clear means a waiting class is never released. Mask or access-rule faults are seen through `reg_rdata_o` right after the offending write. An ordering fault is caught by setting up overlapping pending and nested levels, such as a latch bit re-set during acceptance or a return that retires the wrong level. The check is whether the offer appears in the one cycle the rules allow.

// File: rtl/nec_pkg.sv
package nec_pkg;
  localparam int unsigned NumEv = 16;
  localparam int unsigned IdxW  = $clog2(NumEv);

  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_NEST  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/nec_arb.sv
module nec_arb #(
  parameter int unsigned N      = 16,
  parameter int unsigned N_SYS  = 5,
  parameter int unsigned GP_LO  = 7,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     latch_i,
  input  logic [N-1:0]     mask_i,
  input  logic             gie_i,
  input  logic [N-1:0]     nest_i,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] elig, limit, cand, nest_low;

  for (genvar g = 0; g < N; g++) begin : g_elig
    if (g < N_SYS) begin : g_sys
      assign elig[g] = 1'b1;
    end else if (g < GP_LO) begin : g_msk
      assign elig[g] = mask_i[g];
    end else begin : g_gp
      assign elig[g] = mask_i[g] & gie_i;
    end
  end

  // only classes strictly more urgent than lowest active level
  assign nest_low = nest_i & (~nest_i + 1'b1);
  assign limit    = (nest_i == '0) ? '1 : nest_low - 1'b1;
  assign cand     = latch_i & elig & limit;
  assign req_o    = |cand;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/nec_latch.sv
module nec_latch #(
  parameter int unsigned N      = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     ev_i,
  input  logic             wr_i,
  input  logic [N-1:0]     wdata_i,
  input  logic [N-1:0]     wmask_i,
  input  logic             acc_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  output logic [N-1:0]     latch_o
);
  logic [N-1:0] latch_q, latch_d;

  // order: software write, then accept clear, then capture wins
  always_comb begin
    latch_d = latch_q;
    if (wr_i) latch_d = (latch_d & ~wmask_i) | (wdata_i & wmask_i);
    if (acc_i) latch_d[acc_idx_i] = 1'b0;
    latch_d = latch_d | ev_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= latch_d;
  end

  assign latch_o = latch_q;

  AST_CAPTURE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((latch_q & $past(ev_i)) == $past(ev_i))); // R2
  AST_PROTECTED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !acc_i) |=> ((latch_q & ~$past(wmask_i)) & ~$past(ev_i)) ==
                         ($past(latch_q) & ~$past(wmask_i) & ~$past(ev_i))); // R3
endmodule

// File: rtl/nec_nest.sv
module nec_nest #(
  parameter int unsigned N      = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  input  logic             ret_i,
  output logic [N-1:0]     nest_o
);
  logic [N-1:0] nest_q, nest_d, low;

  assign low = nest_q & (~nest_q + 1'b1);

  always_comb begin
    nest_d = nest_q;
    if (ret_i) nest_d = nest_d & ~low;
    if (acc_i) nest_d[acc_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nest_q <= '0;
    else         nest_q <= nest_d;
  end

  assign nest_o = nest_q;

  AST_RET_DROPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !acc_i && nest_q != '0) |=>
      ($countones(nest_q) + 1 == $countones($past(nest_q)))); // R10
  AST_ACC_SETS_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> nest_q[$past(acc_idx_i)]); // R9
endmodule

// File: rtl/nested_event_ctrl.sv
module nested_event_ctrl
  import nec_pkg::*;
#(
  parameter int unsigned N      = NumEv,
  parameter int unsigned N_SYS  = 5,
  parameter int unsigned GP_LO  = 7,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     ev_req_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             sup_mode_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [N-1:0]     reg_wdata_i,
  output logic [N-1:0]     reg_rdata_o,
  output logic             vec_req_o,
  output logic [IDX_W-1:0] vec_idx_o,
  input  logic             vec_ack_i,
  input  logic             ret_i
);
  reg_sel_e     sel;
  logic [N-1:0] mask_q, latch, nest;
  logic         gie_q, acc, wr_latch, wr_mask;

  assign sel      = reg_sel_e'(reg_sel_i);
  assign wr_latch = reg_wr_i & sup_mode_i & (sel == SEL_LATCH);
  assign wr_mask  = reg_wr_i & sup_mode_i & (sel == SEL_MASK);
  assign acc      = vec_ack_i & vec_req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata_i;
      if (gie_clr_i)      gie_q <= 1'b0;
      else if (gie_set_i) gie_q <= 1'b1;
    end
  end

  nec_latch #(.N(N)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev_req_i),
    .wr_i      (wr_latch),
    .wdata_i   (reg_wdata_i),
    .wmask_i   (~mask_q),
    .acc_i     (acc),
    .acc_idx_i (vec_idx_o),
    .latch_o   (latch)
  );

  nec_nest #(.N(N)) u_nest (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .acc_idx_i (vec_idx_o),
    .ret_i     (ret_i),
    .nest_o    (nest)
  );

  nec_arb #(.N(N), .N_SYS(N_SYS), .GP_LO(GP_LO)) u_arb (
    .latch_i (latch),
    .mask_i  (mask_q),
    .gie_i   (gie_q),
    .nest_i  (nest),
    .req_o   (vec_req_o),
    .idx_o   (vec_idx_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sup_mode_i) begin
      unique case (sel)
        SEL_LATCH: reg_rdata_o = latch;
        SEL_MASK:  reg_rdata_o = mask_q;
        SEL_NEST:  reg_rdata_o = nest;
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  AST_REQ_IS_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> latch[vec_idx_o]); // R8
  AST_REQ_OUTRANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> ((nest & ((N)'(1) << vec_idx_o)) == '0) &&
                  ((nest & (((N)'(1) << vec_idx_o) - 1'b1)) == '0)); // R8
  AST_GIE_GATES_GP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o && !gie_q) |-> (32'(vec_idx_o) < GP_LO)); // R6
  AST_MASK_USER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_mode_i |=> $stable(mask_q)); // R4
  AST_GIE_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_i |=> !gie_q); // R7
  AST_USER_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_mode_i |-> (reg_rdata_o == '0)); // R4
endmodule

// File: tb/nested_event_ctrl_bench.sv
module nested_event_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ev_req_i = '0;
  logic        gie_set_i = 1'b0, gie_clr_i = 1'b0;
  logic        sup_mode_i = 1'b1, reg_wr_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        vec_req_o;
  logic [3:0]  vec_idx_o;
  logic        vec_ack_i = 1'b0, ret_i = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  nested_event_ctrl u_nested_event_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [1:0] sel, input logic sup, output logic [15:0] v);
    reg_sel_i = sel; sup_mode_i = sup;
    #1 v = reg_rdata_o;
    sup_mode_i = 1'b1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic sup, input logic [15:0] d);
    reg_sel_i = sel; sup_mode_i = sup; reg_wdata_i = d; reg_wr_i = 1'b1;
    step();
    reg_wr_i = 1'b0; sup_mode_i = 1'b1;
  endtask

  task automatic pulse_ev(input logic [15:0] b);
    ev_req_i = b; step(); ev_req_i = '0;
  endtask

  task automatic ack(input logic [15:0] also_ev);
    vec_ack_i = 1'b1; ev_req_i = also_ev; step();
    vec_ack_i = 1'b0; ev_req_i = '0;
  endtask

  task automatic ret();
    ret_i = 1'b1; step(); ret_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, 1'b1, v); chk("R1 latch", v, 0);
    rd(2'd1, 1'b1, v); chk("R1 mask", v, 0);
    rd(2'd2, 1'b1, v); chk("R1 nest", v, 0);
    chk("R1 req", vec_req_o, 0);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    pulse_ev(16'h0200);
    rd(2'd0, 1'b1, v); chk("R2 latched while masked", v, 16'h0200);
    chk("R6 masked gp no req", vec_req_o, 0);
    pulse_ev(16'h0008);
    chk("R6 system class req", vec_req_o, 1);
    chk("R8 idx 3", vec_idx_o, 3);
    wr(2'd0, 1'b1, 16'h0000);
    rd(2'd0, 1'b1, v); chk("R3 clear unmasked bits", v, 0);
  endtask

  task automatic t_mid_and_gie();
    logic [15:0] v;
    pulse_ev(16'h0020);
    chk("R6 class5 masked", vec_req_o, 0);
    wr(2'd1, 1'b1, 16'h0220);
    chk("R6 class5 mask only", vec_req_o, 1);
    chk("R6 idx 5", vec_idx_o, 5);
    wr(2'd0, 1'b1, 16'h0000);
    rd(2'd0, 1'b1, v); chk("R3 protected bit kept", v, 16'h0020);
    wr(2'd0, 1'b1, 16'h0020);  // drop class5 via mask then clear
    wr(2'd1, 1'b1, 16'h0200);
    wr(2'd0, 1'b1, 16'h0000);
    pulse_ev(16'h0200);
    chk("R6 gie off blocks gp", vec_req_o, 0);
    gie_set_i = 1'b1; step(); gie_set_i = 1'b0;
    chk("R7 gie on req", vec_req_o, 1);
    chk("R7 idx 9", vec_idx_o, 9);
    gie_set_i = 1'b1; gie_clr_i = 1'b1; step(); gie_set_i = 1'b0; gie_clr_i = 1'b0;
    chk("R7 clear wins", vec_req_o, 0);
    rd(2'd1, 1'b1, v); chk("R7 mask unchanged", v, 16'h0200);
  endtask

  task automatic t_access();
    logic [15:0] v;
    wr(2'd1, 1'b0, 16'hffff);
    rd(2'd1, 1'b1, v); chk("R4 user write ignored", v, 16'h0200);
    rd(2'd1, 1'b0, v); chk("R4 user read zero", v, 0);
    rd(2'd0, 1'b0, v); chk("R4 user latch read zero", v, 0);
    wr(2'd2, 1'b1, 16'hffff);
    rd(2'd2, 1'b1, v); chk("R5 nest write ignored", v, 0);
    rd(2'd3, 1'b1, v); chk("R5 sel3 reads zero", v, 0);
  endtask

  task automatic t_nesting();
    logic [15:0] v;
    wr(2'd1, 1'b1, 16'hffff);
    gie_set_i = 1'b1; step(); gie_set_i = 1'b0;
    chk("R8 idx 9 pending", vec_idx_o, 9);
    ack('0);
    rd(2'd2, 1'b1, v); chk("R9 nest set", v, 16'h0200);
    rd(2'd0, 1'b1, v); chk("R9 latch cleared", v, 0);
    pulse_ev(16'h1000);
    chk("R8 lower prio held", vec_req_o, 0);
    pulse_ev(16'h0080);
    chk("R8 preempt req", vec_req_o, 1);
    chk("R8 preempt idx 7", vec_idx_o, 7);
    ack(16'h0080);
    rd(2'd2, 1'b1, v); chk("R9 nested two", v, 16'h0280);
    rd(2'd0, 1'b1, v); chk("R9 relatch same cycle", v, 16'h1080);
    chk("R8 equal level no req", vec_req_o, 0);
    ret();
    rd(2'd2, 1'b1, v); chk("R10 lowest cleared", v, 16'h0200);
    chk("R10 rearb req", vec_req_o, 1);
    chk("R10 rearb idx 7", vec_idx_o, 7);
    ack('0);
    ret();
    rd(2'd2, 1'b1, v); chk("R10 back to 9", v, 16'h0200);
    chk("R8 12 below 9 held", vec_req_o, 0);
    ret();
    rd(2'd2, 1'b1, v); chk("R10 nest empty", v, 0);
    chk("R10 idx 12 released", vec_idx_o, 12);
    chk("R10 req 12", vec_req_o, 1);
    ack('0);
    ret();
    rd(2'd2, 1'b1, v); chk("R10 final nest", v, 0);
    chk("R9 no req left", vec_req_o, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_capture();
    t_mid_and_gie();
    t_access();
    t_nesting();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule